// File: doc/BRIEF.md
# Redundant Store Comparison Buffer

This block guards memory against soft errors when one program runs as two redundant threads. The leading thread hands each store (address and data) to the block, which holds it in an in-order queue. The store stays there until the trailing thread produces its own copy of the same store. Only when the two copies agree in both address and data is the leading store written to memory. Trailing stores are used only for the comparison and never reach the memory port. Instructions other than stores are not seen by this block.

When the queue holds its full capacity of entries, a stall signal tells the leading thread to halt. The entry at the head is always the one compared. A disagreement in any bit of address or data raises a fault flag, and the block then stays silent toward memory until reset. A trailing store that arrives when nothing is queued is a protocol error and raises the same flag.

Top module: `store_check_buf`

## Requirements
- R1: After reset, stall_o, fault_o and mem_we_o are all 0.
- R2: A trailing store whose address and data both equal the oldest queued leading store drives mem_we_o high for exactly one cycle, in the cycle after the compare, with mem_addr_o and mem_data_o equal to the leading store's values, and removes that entry.
- R3: Queued stores are released to memory strictly in the order the leading thread pushed them.
- R4: stall_o is 1 exactly when DEPTH (default 160) entries are queued; a push while stall_o is 1 and no release happens in that cycle is dropped.
- R5: A trailing store whose address differs from the head entry in any single bit sets fault_o in the next cycle, and no memory write occurs.
- R6: A trailing store whose data differs from the head entry in any single bit sets fault_o in the next cycle, and no memory write occurs.
- R7: Once fault_o is 1 it stays 1 until reset, and no further memory write occurs even for matching trailing stores.
- R8: A trailing store arriving while the queue is empty sets fault_o in the next cycle and writes nothing.
- R9: A push and a compare in the same cycle are both served: the compare uses the entry that was the head before the cycle, and the pushed store is queued; with the queue full, a push together with a matching compare is accepted and stall_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lead_vld_i | input | 1 | Leading thread presents a store |
| lead_addr_i | input | ADDR_W | Leading store address |
| lead_data_i | input | DATA_W | Leading store data |
| stall_o | output | 1 | Queue full, leading thread must halt |
| trail_vld_i | input | 1 | Trailing thread presents a store for comparison |
| trail_addr_i | input | ADDR_W | Trailing store address |
| trail_data_i | input | DATA_W | Trailing store data |
| mem_we_o | output | 1 | Memory write strobe for a verified store |
| mem_addr_o | output | ADDR_W | Verified store address |
| mem_data_o | output | DATA_W | Verified store data |
| fault_o | output | 1 | Sticky mismatch or protocol-error flag |

## Verification
The two functions that can coincide are a leading push and a trailing compare, which may land on the same clock edge. The bench drives both in one cycle on a queue holding one entry, and again on a completely full queue, and judges that the write carries the old head entry, that the new store is released later in order, and that the stall output stays asserted through the full-queue case. A push into an empty queue together with a compare is also covered by the rule that the compare sees the empty queue and faults.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_DEPTH  = 160;

  typedef enum logic [1:0] {
    CMP_IDLE  = 2'd0,
    CMP_PASS  = 2'd1,
    CMP_DIFF  = 2'd2,
    CMP_EMPTY = 2'd3
  } cmp_res_e;
endpackage

// File: rtl/scb_fifo.sv
module scb_fifo #(
  parameter int unsigned DEPTH = 160,
  parameter int unsigned W     = 96
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_pop  = pop_i && !empty_o;
  // a slot freed this cycle may be refilled in the same cycle
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  a_r4_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);
  a_r9_full_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i) |=> full_o);
endmodule

// File: rtl/scb_cmp.sv
module scb_cmp
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              vld_i,
  input  logic              empty_i,
  input  logic              halt_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [ADDR_W-1:0] trail_addr_i,
  input  logic [DATA_W-1:0] trail_data_i,
  output cmp_res_e          res_o
);
  logic addr_eq, data_eq;

  assign addr_eq = (head_addr_i == trail_addr_i);
  assign data_eq = (head_data_i == trail_data_i);

  always_comb begin
    if (!vld_i || halt_i)      res_o = CMP_IDLE;
    else if (empty_i)          res_o = CMP_EMPTY;
    else if (addr_eq && data_eq) res_o = CMP_PASS;
    else                       res_o = CMP_DIFF;
  end
endmodule

// File: rtl/scb_release.sv
module scb_release
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmp_res_e          res_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  output logic              fault_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic fault_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q <= (res_i == CMP_PASS);
      if (res_i == CMP_PASS) begin
        addr_q <= head_addr_i;
        data_q <= head_data_i;
      end
      if (res_i == CMP_DIFF || res_i == CMP_EMPTY) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  a_r7_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
  a_r7_silent_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !we_o);
  a_r5_no_write_on_fault_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> !we_o);
endmodule

// File: rtl/store_check_buf.sv
module store_check_buf
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_vld_i,
  input  logic [ADDR_W-1:0] lead_addr_i,
  input  logic [DATA_W-1:0] lead_data_i,
  output logic              stall_o,
  input  logic              trail_vld_i,
  input  logic [ADDR_W-1:0] trail_addr_i,
  input  logic [DATA_W-1:0] trail_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              fault_o
);
  localparam int unsigned EW = ADDR_W + DATA_W;

  logic [EW-1:0]     head;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic              empty, full, pop;
  cmp_res_e          res;

  assign head_addr = head[EW-1:DATA_W];
  assign head_data = head[DATA_W-1:0];
  assign pop       = (res == CMP_PASS);
  assign stall_o   = full;

  scb_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (lead_vld_i),
    .data_i  ({lead_addr_i, lead_data_i}),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  scb_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .vld_i        (trail_vld_i),
    .empty_i      (empty),
    .halt_i       (fault_o),
    .head_addr_i  (head_addr),
    .head_data_i  (head_data),
    .trail_addr_i (trail_addr_i),
    .trail_data_i (trail_data_i),
    .res_o        (res)
  );

  scb_release #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_i       (res),
    .head_addr_i (head_addr),
    .head_data_i (head_data),
    .fault_o     (fault_o),
    .we_o        (mem_we_o),
    .addr_o      (mem_addr_o),
    .data_o      (mem_data_o)
  );

  a_r8_empty_compare: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_vld_i && empty) |=> (fault_o && !mem_we_o));
  a_r2_write_needs_compare: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(trail_vld_i));
  a_r2_write_matches_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == $past(trail_addr_i) && mem_data_o == $past(trail_data_i)));
endmodule

// File: tb/store_check_buf_tb_top.sv
module store_check_buf_tb_top;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int DEPTH = 160;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lead_vld = 1'b0;
  logic [AW-1:0] lead_addr = '0;
  logic [DW-1:0] lead_data = '0;
  logic trail_vld = 1'b0;
  logic [AW-1:0] trail_addr = '0;
  logic [DW-1:0] trail_data = '0;
  logic stall, mem_we, fault;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  store_check_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lead_vld_i(lead_vld), .lead_addr_i(lead_addr), .lead_data_i(lead_data),
    .stall_o(stall),
    .trail_vld_i(trail_vld), .trail_addr_i(trail_addr), .trail_data_i(trail_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .fault_o(fault)
  );

  function automatic logic [AW-1:0] pa(int i);
    return AW'(32'h1000_0000 + i * 8);
  endfunction
  function automatic logic [DW-1:0] pd(int i);
    return {32'(i * 7 + 3), 32'hC0DE_0000 ^ 32'(i)};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    lead_vld = 1'b0;
    trail_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one cycle: optional push and optional compare, outputs sampled one edge later
  task automatic cyc(bit p, int pi, bit c, logic [AW-1:0] ca, logic [DW-1:0] cd);
    lead_vld = p;
    lead_addr = pa(pi);
    lead_data = pd(pi);
    trail_vld = c;
    trail_addr = ca;
    trail_data = cd;
    @(negedge clk);
    lead_vld = 1'b0;
    trail_vld = 1'b0;
  endtask

  task automatic expect_write(int i, string req);
    chk(mem_we === 1'b1, req, DW'(mem_we), 1);
    chk(mem_addr === pa(i), req, DW'(mem_addr), DW'(pa(i)));
    chk(mem_data === pd(i), req, mem_data, pd(i));
  endtask

  task automatic t_reset();
    do_reset();
    chk(stall === 1'b0, "R1 stall", DW'(stall), 0);
    chk(fault === 1'b0, "R1 fault", DW'(fault), 0);
    chk(mem_we === 1'b0, "R1 we", DW'(mem_we), 0);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, i, 0, '0, '0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, pa(i), pd(i));
      expect_write(i, "R3 order");
    end
    @(negedge clk);
    chk(mem_we === 1'b0, "R2 single pulse", DW'(mem_we), 0);
    chk(fault === 1'b0, "R2 no fault", DW'(fault), 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    cyc(1, 10, 0, '0, '0);
    cyc(1, 11, 1, pa(10), pd(10));
    expect_write(10, "R9 old head");
    cyc(0, 0, 1, pa(11), pd(11));
    expect_write(11, "R9 pushed kept");
    // push into empty with compare: compare sees empty
    cyc(1, 12, 1, pa(12), pd(12));
    chk(fault === 1'b1, "R8 empty with push", DW'(fault), 1);
    chk(mem_we === 1'b0, "R8 no write", DW'(mem_we), 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      chk(stall === 1'b0, "R4 not full yet", DW'(stall), 0);
      cyc(1, i, 0, '0, '0);
    end
    chk(stall === 1'b1, "R4 full", DW'(stall), 1);
    cyc(1, 999, 0, '0, '0);
    chk(stall === 1'b1, "R4 still full", DW'(stall), 1);
    cyc(1, DEPTH, 1, pa(0), pd(0));
    expect_write(0, "R9 full swap");
    chk(stall === 1'b1, "R9 stall kept", DW'(stall), 1);
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(0, 0, 1, pa(i), pd(i));
      expect_write(i, "R4 drop check");
    end
    chk(stall === 1'b0, "R4 drained", DW'(stall), 0);
    chk(fault === 1'b0, "R4 no fault", DW'(fault), 0);
  endtask

  task automatic t_addr_bad();
    do_reset();
    cyc(1, 20, 0, '0, '0);
    cyc(0, 0, 1, pa(20) ^ AW'(32'h0000_0100), pd(20));
    chk(fault === 1'b1, "R5 fault", DW'(fault), 1);
    chk(mem_we === 1'b0, "R5 no write", DW'(mem_we), 0);
  endtask

  task automatic t_data_bad_sticky();
    do_reset();
    cyc(1, 30, 0, '0, '0);
    cyc(1, 31, 0, '0, '0);
    cyc(0, 0, 1, pa(30), pd(30) ^ DW'(64'h8000_0000_0000_0000));
    chk(fault === 1'b1, "R6 fault", DW'(fault), 1);
    chk(mem_we === 1'b0, "R6 no write", DW'(mem_we), 0);
    cyc(0, 0, 1, pa(30), pd(30));
    chk(mem_we === 1'b0, "R7 blocked head", DW'(mem_we), 0);
    cyc(0, 0, 1, pa(31), pd(31));
    chk(mem_we === 1'b0, "R7 blocked next", DW'(mem_we), 0);
    repeat (3) @(negedge clk);
    chk(fault === 1'b1, "R7 sticky", DW'(fault), 1);
    do_reset();
    chk(fault === 1'b0, "R7 cleared by reset", DW'(fault), 0);
  endtask

  task automatic t_empty();
    do_reset();
    cyc(0, 0, 1, pa(5), pd(5));
    chk(fault === 1'b1, "R8 fault", DW'(fault), 1);
    chk(mem_we === 1'b0, "R8 no write", DW'(mem_we), 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_same_cycle();
    t_full();
    t_addr_bad();
    t_data_bad_sticky();
    t_empty();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule